// File: doc/BRIEF.md
# Nibble-Wide Double-Rate Link Port

This block is one end of a full-duplex, point-to-point link that moves 128-bit quad words over two 4-bit paths, one outgoing and one incoming. Both paths carry data at double rate. The block models this synchronously as a pair of nibbles in every clock cycle, so one quad word takes 16 cycles on the wire. A core or DMA writer pushes quad words into a two-entry transmit buffer. A serialiser sends them with the least-significant nibble first and raises a start strobe on the first pair of each quad word. On the incoming side, a deserialiser rebuilds quad words into a three-entry receive buffer, which a reader drains in arrival order.

Flow control is a single acknowledge line from the receiver. It goes low when every receive entry is either holding a complete quad word or reserved by the quad word being collected. A transmitter that sees it low does not begin a new quad word. Two ports are joined by connecting each transmit path and start strobe to the other's receive inputs, and each acknowledge output to the other's acknowledge input.

The transmit machine has two states. TX_IDLE moves to TX_SEND (launch) when the buffer holds an entry and acknowledge is high. TX_SEND counts 16 beats. After the last beat it either launches the next entry straight away (back-to-back) or returns to TX_IDLE (drain or blocked). The receive machine also has two states. RX_IDLE moves to RX_COLLECT (capture) on a start strobe while acknowledge is high. RX_COLLECT returns to RX_IDLE (commit) after its 16th beat and stores the quad word.

Top module: `nibble_link_port`

## Requirements
- R1: After reset, wr_ready is 1, rd_valid is 0, tx_start is 0 and rx_ack_out is 1.
- R2: A quad word goes out over 16 consecutive cycles. In beat k, tx_lo carries bits [8k+3:8k] and tx_hi carries bits [8k+7:8k+4]. The first beat therefore holds the least-significant nibble on tx_lo.
- R3: tx_start is 1 only in the first beat of a quad word. When a second quad word is waiting and acknowledge stays high, its start comes exactly 16 cycles after the previous one.
- R4: wr_ready is 0 exactly when both transmit entries are occupied. A write is taken only in a cycle where wr_valid and wr_ready are both 1.
- R5: The receiver begins capturing only on a cycle with rx_start at 1. Nibbles presented outside a quad word are ignored.
- R6: rd_valid is 1 while at least one complete quad word is stored. On an idle looped-back link, it rises 17 clock edges after the edge that accepted the write.
- R7: rx_ack_out is 0 whenever stored quad words plus the one being collected equal three.
- R8: The transmitter does not begin a quad word in any cycle after one where tx_ack_in was 0 at its decision point.
- R9: An rx_start that arrives while rx_ack_out is 0 is ignored and adds no entry.
- R10: rd_data shows the oldest stored quad word. rd_en with rd_valid removes it, so quad words leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Writer offers a quad word |
| wr_data | input | 128 | Quad word to send |
| wr_ready | output | 1 | Transmit buffer has a free entry |
| rd_en | input | 1 | Reader takes the oldest quad word |
| rd_data | output | 128 | Oldest received quad word |
| rd_valid | output | 1 | At least one received quad word is stored |
| tx_lo | output | 4 | Outgoing lower nibble of the pair |
| tx_hi | output | 4 | Outgoing upper nibble of the pair |
| tx_start | output | 1 | First nibble pair of an outgoing quad word |
| tx_ack_in | input | 1 | Far receiver can take a new quad word |
| rx_lo | input | 4 | Incoming lower nibble of the pair |
| rx_hi | input | 4 | Incoming upper nibble of the pair |
| rx_start | input | 1 | First nibble pair of an incoming quad word |
| rx_ack_out | output | 1 | This receiver can take a new quad word |

## Verification
The bench loops the port back to itself and writes five table words with the reader held off. It then checks four things: the receive side stops at three words, acknowledge drops, the transmit buffer reports full, and no start appears. If the reservation count were wrong, a fourth word would overwrite or be lost. With the buffers full it drives a forged start strobe, which a design that ignored acknowledge on capture would store or corrupt. It also reconstructs the outgoing word from the pins to catch swapped lanes or a reversed nibble order. Finally it measures the spacing of back-to-back starts, which exposes an idle bubble or an early launch.

// File: rtl/lp_pkg.sv
package lp_pkg;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;
    typedef enum logic {RX_IDLE, RX_COLLECT} rx_state_e;
endpackage

// File: rtl/lp_fifo.sv
module lp_fifo #(
    parameter int W     = 128,
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push) wptr <= step(wptr);
            if (pop)  rptr <= step(rptr);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rptr];
    assign count = cnt;

    // R4: never written beyond capacity
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH)) |-> !push);
    // R10: never read while empty
    a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !pop);
endmodule

// File: rtl/lp_tx.sv
module lp_tx
    import lp_pkg::*;
#(
    parameter int QW = 128,
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          have,
    input  logic [QW-1:0] head,
    output logic          take,
    input  logic          ack_in,
    output logic [NW-1:0] lo,
    output logic [NW-1:0] hi,
    output logic          start
);
    localparam int BEATS = QW / (2*NW);
    localparam int BW    = $clog2(BEATS);

    tx_state_e     st, nxt_st;
    logic [BW-1:0] beat;
    logic [QW-1:0] sh;
    logic          last, launch;

    assign last   = (st == TX_SEND) && (beat == BW'(BEATS-1));
    assign launch = have && ack_in && ((st == TX_IDLE) || last);

    always_comb begin
        nxt_st = st;
        unique case (st)
            TX_IDLE: if (launch) nxt_st = TX_SEND;
            TX_SEND: if (last && !launch) nxt_st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            beat <= '0;
            sh   <= '0;
        end else begin
            st <= nxt_st;
            if (launch) begin
                beat <= '0;
                sh   <= head;
            end else if (st == TX_SEND) begin
                beat <= beat + 1'b1;
                sh   <= sh >> (2*NW);
            end
        end
    end

    always_comb begin
        take  = launch;
        start = (st == TX_SEND) && (beat == '0);
        lo    = sh[NW-1:0];
        hi    = sh[2*NW-1:NW];
    end

    // R8: a refused acknowledge at a decision point blocks the next start
    a_r8_hold_on_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_in && ((st == TX_IDLE) || last)) |=> !start);
    // R3: starts are never on consecutive cycles
    a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/lp_rx.sv
module lp_rx
    import lp_pkg::*;
#(
    parameter int QW    = 128,
    parameter int NW    = 4,
    parameter int DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NW-1:0]               lo,
    input  logic [NW-1:0]               hi,
    input  logic                        start,
    input  logic [$clog2(DEPTH+1)-1:0]  stored,
    output logic                        push,
    output logic [QW-1:0]               push_data,
    output logic                        ack
);
    localparam int BEATS = QW / (2*NW);
    localparam int BW    = $clog2(BEATS);
    localparam int CW    = $clog2(DEPTH+1);

    rx_state_e     st, nxt_st;
    logic [BW-1:0] beat;
    logic [QW-1:0] sh;
    logic [CW:0]   reserved;
    logic          capture, last;

    assign reserved = {1'b0, stored} + (CW+1)'(st == RX_COLLECT);
    assign ack      = reserved < (CW+1)'(DEPTH);
    assign capture  = (st == RX_IDLE) && start && ack;
    assign last     = (st == RX_COLLECT) && (beat == BW'(BEATS-1));

    always_comb begin
        nxt_st = st;
        unique case (st)
            RX_IDLE:    if (capture) nxt_st = RX_COLLECT;
            RX_COLLECT: if (last)    nxt_st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            beat <= '0;
            sh   <= '0;
        end else begin
            st <= nxt_st;
            if (capture) begin
                beat <= BW'(1);
                sh   <= {hi, lo, sh[QW-1:2*NW]};
            end else if (st == RX_COLLECT) begin
                beat <= beat + 1'b1;
                sh   <= {hi, lo, sh[QW-1:2*NW]};
            end
        end
    end

    always_comb begin
        push      = last;
        push_data = {hi, lo, sh[QW-1:2*NW]};
    end

    // R9: with acknowledge low the receiver stays idle whatever arrives
    a_r9_ignore_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == RX_IDLE) && !ack) |=> (st == RX_IDLE));
endmodule

// File: rtl/nibble_link_port.sv
module nibble_link_port #(
    parameter int QW       = 128,
    parameter int NW       = 4,
    parameter int TX_DEPTH = 2,
    parameter int RX_DEPTH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [QW-1:0] wr_data,
    output logic          wr_ready,
    input  logic          rd_en,
    output logic [QW-1:0] rd_data,
    output logic          rd_valid,
    output logic [NW-1:0] tx_lo,
    output logic [NW-1:0] tx_hi,
    output logic          tx_start,
    input  logic          tx_ack_in,
    input  logic [NW-1:0] rx_lo,
    input  logic [NW-1:0] rx_hi,
    input  logic          rx_start,
    output logic          rx_ack_out
);
    localparam int TCW = $clog2(TX_DEPTH+1);
    localparam int RCW = $clog2(RX_DEPTH+1);

    logic [TCW-1:0] tx_cnt;
    logic [RCW-1:0] rx_cnt;
    logic [QW-1:0]  tx_head, rx_word;
    logic           tx_take, rx_push, wr_fire, rd_fire;

    assign wr_ready = (tx_cnt != TCW'(TX_DEPTH));
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_valid = (rx_cnt != '0);
    assign rd_fire  = rd_en && rd_valid;

    lp_fifo #(.W(QW), .DEPTH(TX_DEPTH)) u_tx_buf (
        .clk(clk), .rst_n(rst_n), .push(wr_fire), .push_data(wr_data),
        .pop(tx_take), .head(tx_head), .count(tx_cnt)
    );

    lp_tx #(.QW(QW), .NW(NW)) u_tx (
        .clk(clk), .rst_n(rst_n), .have(tx_cnt != '0), .head(tx_head),
        .take(tx_take), .ack_in(tx_ack_in), .lo(tx_lo), .hi(tx_hi),
        .start(tx_start)
    );

    lp_rx #(.QW(QW), .NW(NW), .DEPTH(RX_DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n), .lo(rx_lo), .hi(rx_hi), .start(rx_start),
        .stored(rx_cnt), .push(rx_push), .push_data(rx_word), .ack(rx_ack_out)
    );

    lp_fifo #(.W(QW), .DEPTH(RX_DEPTH)) u_rx_buf (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
        .pop(rd_fire), .head(rd_data), .count(rx_cnt)
    );

    // R6: a stored word stays visible until the reader takes it
    a_r6_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_en) |=> rd_valid);
    // R4: a full transmit buffer keeps refusing until the serialiser takes an entry
    a_r4_ready_held_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && !tx_take) |=> !wr_ready);
endmodule

// File: tb/nibble_link_port_tb.sv
module nibble_link_port_tb;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         wr_valid = 0;
    logic [127:0] wr_data = '0;
    logic         wr_ready;
    logic         rd_en = 0;
    logic [127:0] rd_data;
    logic         rd_valid;
    logic [3:0]   tx_lo, tx_hi, rx_lo, rx_hi;
    logic         tx_start, rx_start, rx_ack_out, tx_ack_in;
    logic         loop_en = 1;
    logic [3:0]   drv_lo = 0, drv_hi = 0;
    logic         drv_start = 0;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    assign rx_lo     = loop_en ? tx_lo : drv_lo;
    assign rx_hi     = loop_en ? tx_hi : drv_hi;
    assign rx_start  = loop_en ? tx_start : drv_start;
    assign tx_ack_in = rx_ack_out;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nibble_link_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .tx_lo(tx_lo), .tx_hi(tx_hi), .tx_start(tx_start), .tx_ack_in(tx_ack_in),
        .rx_lo(rx_lo), .rx_hi(rx_hi), .rx_start(rx_start), .rx_ack_out(rx_ack_out)
    );

    localparam logic [127:0] VEC [6] = '{
        128'h0123456789ABCDEF_FEDCBA9876543210,
        128'hDEADBEEF_CAFEF00D_0BADC0DE_12345678,
        128'hFFFFFFFF_00000000_FFFFFFFF_00000000,
        128'hA5A5A5A5_5A5A5A5A_3C3C3C3C_C3C3C3C3,
        128'h00000000_00000000_00000000_00000001,
        128'h80000000_00000000_00000000_0000000F
    };

    // transmit pin monitor, sampled away from the active edge
    logic [127:0] mon_word, last_frame;
    int mon_idx = 16, frames = 0, starts = 0, t_start = 0, t_prev = 0;
    logic [3:0] first_lo, first_hi;
    always @(negedge clk) begin
        if (rst_n && tx_start) begin
            mon_word[7:0] = {tx_hi, tx_lo};
            first_lo = tx_lo; first_hi = tx_hi;
            mon_idx = 1; starts++;
            t_prev = t_start; t_start = cyc;
        end else if (rst_n && mon_idx < 16) begin
            mon_word[mon_idx*8 +: 8] = {tx_hi, tx_lo};
            mon_idx++;
            if (mon_idx == 16) begin last_frame = mon_word; frames++; end
        end
    end

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [127:0] d, output bit ok);
        ok = 0;
        wr_data = d; wr_valid = 1;
        for (int i = 0; i < 300; i++) begin
            if (wr_ready) begin ok = 1; break; end
            @(negedge clk);
        end
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic read_word(output logic [127:0] d, output bit ok);
        ok = 0; d = '0;
        for (int i = 0; i < 300; i++) begin
            if (rd_valid) begin ok = 1; break; end
            @(negedge clk);
        end
        if (ok) begin
            d = rd_data; rd_en = 1;
            @(negedge clk);
            rd_en = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ok;
        logic [127:0] d;
        int n, s0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(wr_ready == 1, "R1 wr_ready", 128'(wr_ready), 1);
        check(rd_valid == 0, "R1 rd_valid", 128'(rd_valid), 0);
        check(tx_start == 0, "R1 tx_start", 128'(tx_start), 0);
        check(rx_ack_out == 1, "R1 rx_ack_out", 128'(rx_ack_out), 1);

        // R5: nibbles without a start strobe are ignored
        loop_en = 0; drv_lo = 4'hA; drv_hi = 4'h5;
        repeat (20) @(negedge clk);
        check(rd_valid == 0, "R5 no capture without start", 128'(rd_valid), 0);
        loop_en = 1;

        // table walk: fill the link with the reader held off
        for (int i = 0; i < 5; i++) begin
            write_word(VEC[i], ok);
            check(ok, "R4 write accepted", 128'(ok), 1);
        end
        repeat (80) @(negedge clk);
        check(rx_ack_out == 0, "R7 ack low with three stored", 128'(rx_ack_out), 0);
        check(wr_ready == 0, "R4 ready low with two buffered", 128'(wr_ready), 0);
        s0 = starts;
        repeat (40) @(negedge clk);
        check(starts == s0, "R8 no start while ack low", 128'(starts), 128'(s0));

        // R9: forged start while full
        loop_en = 0; drv_start = 1; drv_lo = 4'hF; drv_hi = 4'hF;
        @(negedge clk);
        drv_start = 0;
        repeat (20) @(negedge clk);
        loop_en = 1;

        read_word(d, ok);
        check(ok && d == VEC[0], "R10 order word 0", d, VEC[0]);
        write_word(VEC[5], ok);
        check(ok, "R4 write after space frees", 128'(ok), 1);
        for (int i = 1; i < 6; i++) begin
            read_word(d, ok);
            check(ok && d == VEC[i], "R10 order", d, VEC[i]);
        end
        repeat (60) @(negedge clk);
        check(rd_valid == 0, "R9 no extra word stored", 128'(rd_valid), 0);

        // R6 latency on an idle link
        write_word(VEC[1], ok);
        n = 0;
        while (!rd_valid && n < 100) begin @(negedge clk); n++; end
        check(n == 17, "R6 latency", 128'(n), 17);
        check(last_frame == VEC[1], "R2 pin order", last_frame, VEC[1]);
        check(first_lo == VEC[1][3:0] && first_hi == VEC[1][7:4], "R2 first pair",
              128'({first_hi, first_lo}), 128'(VEC[1][7:0]));
        read_word(d, ok);

        // R3 back-to-back spacing
        write_word(VEC[2], ok);
        write_word(VEC[3], ok);
        repeat (50) @(negedge clk);
        check(t_start - t_prev == 16, "R3 start spacing", 128'(t_start - t_prev), 16);
        check(last_frame == VEC[3], "R2 second frame", last_frame, VEC[3]);
        read_word(d, ok);
        check(ok && d == VEC[2], "R10 b2b first", d, VEC[2]);
        read_word(d, ok);
        check(ok && d == VEC[3], "R10 b2b second", d, VEC[3]);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule